// File: doc/BRIEF.md
# Two-Bit Branch Predictor with Target Buffer

This block sits beside the fetch stage of a pipelined processor and guesses the next fetch address. It keeps a direct-mapped table of two-bit saturating counters and a direct-mapped branch target buffer. Both are indexed by the low word-address bits of the program counter. For each fetch request it returns, one cycle later, a predicted next PC. That is the cached target when the buffer hits and the counter leans taken. In every other case it is the sequential address PC+4, so the static fallback is "not taken".

When a branch resolves later in the pipeline, the resolve port supplies four things: the branch PC, the real outcome, the real target, and the prediction that fetch made for it. The block trains the counter and writes the target into the buffer on taken branches. One cycle later it raises a mispredict flag together with the corrected fetch address, so the pipeline can flush. The counters give hysteresis: a strongly biased branch survives one contrary outcome without changing its predicted direction. As a result, a loop-closing branch costs one misprediction per loop exit rather than two.

Top module: `bp_core`

## Requirements
- R1: A synchronous active-high reset clears pred_valid, pred_taken and mispredict. It sets every counter to the weak not-taken state 2'b01 and marks every target buffer entry invalid.
- R2: The entry index is pc[IDX_W+1:2], and the tag is pc[31:IDX_W+2]. A buffer hit needs the entry's valid bit set and its stored tag equal to the tag of the fetch PC. Two PCs that share an index but differ in tag do not hit each other's entry.
- R3: In the cycle after fetch_valid is high, pred_valid is 1. pred_taken is 1 and pred_pc equals the cached target only when the buffer hits and counter bit 1 is set. Otherwise pred_taken is 0 and pred_pc is the fetch PC plus 4. Without fetch_valid, pred_valid is 0 in the next cycle.
- R4: A taken resolve increments the indexed counter, saturating at 2'b11. A not-taken resolve decrements it, saturating at 2'b00. States 2'b00 and 2'b01 predict not taken; states 2'b10 and 2'b11 predict taken.
- R5: From state 2'b11, a single not-taken outcome leaves the prediction taken. The predicted direction flips only after two successive mispredictions.
- R6: A taken resolve writes the tag, the target and a set valid bit into the indexed buffer entry. A not-taken resolve leaves the buffer entry unchanged.
- R7: In the cycle after res_valid, mispredict is 1 when one of two conditions holds: res_taken differs from res_pred_taken, or both are 1 and res_target differs from res_pred_target. It is 0 otherwise, and it is 0 in any cycle not preceded by res_valid. In the same cycle, fix_pc holds res_target for a taken branch and res_pc plus 4 for a not-taken branch.
- R8: A fetch and a resolve to the same index in the same cycle give a prediction built from the state before that resolve's update.
- R9: A loop branch taken three times and then not taken, repeated, mispredicts only once at the second loop exit and not on re-entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | Fetch lookup request |
| fetch_pc | input | 32 | PC being fetched |
| pred_valid | output | 1 | Prediction available (one cycle after request) |
| pred_taken | output | 1 | Prediction is a taken branch with known target |
| pred_pc | output | 32 | Predicted next fetch address |
| res_valid | input | 1 | Branch resolution strobe |
| res_pc | input | 32 | PC of the resolved branch |
| res_taken | input | 1 | Actual outcome |
| res_target | input | 32 | Actual taken target |
| res_pred_taken | input | 1 | Direction that fetch predicted for this branch |
| res_pred_target | input | 32 | Next PC that fetch predicted for this branch |
| mispredict | output | 1 | Flush request, one cycle after res_valid |
| fix_pc | output | 32 | Correct next fetch address for the flush |

## Verification
A lookup and a training update can fall on the same clock edge and address the same table entry. The bench provokes this by asserting fetch_valid and res_valid together for a never-seen PC whose branch resolves taken. It then judges two results. The prediction returned in the following cycle must still be sequential, because it was built from the old state. The mispredict flag must be raised in that same cycle. A second fetch of that PC must then return the freshly written target.

// File: rtl/bp_pkg.sv
package bp_pkg;
  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_WEAK_NT = 2'b01;

  function automatic ctr_t ctr_step(input ctr_t cur, input logic taken);
    ctr_t nxt;
    if (taken) nxt = (cur == 2'b11) ? cur : cur + 2'd1;
    else       nxt = (cur == 2'b00) ? cur : cur - 2'd1;
    return nxt;
  endfunction
endpackage

// File: rtl/bp_dir_table.sv
module bp_dir_table
  import bp_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output ctr_t             rd_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken
);
  localparam int DEPTH = 1 << IDX_W;

  ctr_t tbl [DEPTH];

  // counters are small enough to live in flops so reset is single-cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) tbl[i] <= CTR_WEAK_NT;
    end else if (wr_en) begin
      tbl[wr_idx] <= ctr_step(tbl[wr_idx], wr_taken);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_ctr <= CTR_WEAK_NT;
    else if (rd_en) rd_ctr <= tbl[rd_idx];
  end
endmodule

// File: rtl/bp_tgt_buf.sv
module bp_tgt_buf #(
  parameter int IDX_W = 6,
  parameter int TAG_W = 24,
  parameter int PC_W  = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [TAG_W-1:0] rd_tag,
  output logic [PC_W-1:0]  rd_tgt,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [PC_W-1:0]  wr_tgt
);
  localparam int DEPTH = 1 << IDX_W;

  logic             vld     [DEPTH];
  logic [TAG_W-1:0] tag_mem [DEPTH];
  logic [PC_W-1:0]  tgt_mem [DEPTH];

  // valid bits need reset; tag and target are plain RAM
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) vld[i] <= 1'b0;
    end else if (wr_en) begin
      vld[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_idx] <= wr_tag;
      tgt_mem[wr_idx] <= wr_tgt;
    end
  end

  always_ff @(posedge clk) begin
    if (rd_en) begin
      rd_tag <= tag_mem[rd_idx];
      rd_tgt <= tgt_mem[rd_idx];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_valid <= 1'b0;
    else if (rd_en) rd_valid <= vld[rd_idx];
  end
endmodule

// File: rtl/bp_core.sv
module bp_core
  import bp_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fetch_valid,
  input  logic [PC_W-1:0] fetch_pc,
  output logic            pred_valid,
  output logic            pred_taken,
  output logic [PC_W-1:0] pred_pc,
  input  logic            res_valid,
  input  logic [PC_W-1:0] res_pc,
  input  logic            res_taken,
  input  logic [PC_W-1:0] res_target,
  input  logic            res_pred_taken,
  input  logic [PC_W-1:0] res_pred_target,
  output logic            mispredict,
  output logic [PC_W-1:0] fix_pc
);
  localparam int TAG_W = PC_W - IDX_W - 2;
  localparam int TAG_L = IDX_W + 2;

  logic [IDX_W-1:0] f_idx, r_idx;
  logic [TAG_W-1:0] r_tag, q_tag;
  logic [PC_W-1:0]  pc_q, q_tgt;
  logic             q_valid, hit, lean_taken;
  ctr_t             q_ctr;

  assign f_idx = fetch_pc[TAG_L-1:2];
  assign r_idx = res_pc[TAG_L-1:2];
  assign r_tag = res_pc[PC_W-1:TAG_L];

  bp_dir_table #(.IDX_W(IDX_W)) u_dir (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (fetch_valid),
    .rd_idx   (f_idx),
    .rd_ctr   (q_ctr),
    .wr_en    (res_valid),
    .wr_idx   (r_idx),
    .wr_taken (res_taken)
  );

  bp_tgt_buf #(.IDX_W(IDX_W), .TAG_W(TAG_W), .PC_W(PC_W)) u_btb (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (fetch_valid),
    .rd_idx   (f_idx),
    .rd_valid (q_valid),
    .rd_tag   (q_tag),
    .rd_tgt   (q_tgt),
    .wr_en    (res_valid && res_taken),
    .wr_idx   (r_idx),
    .wr_tag   (r_tag),
    .wr_tgt   (res_target)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pred_valid <= 1'b0;
      pc_q       <= '0;
    end else begin
      pred_valid <= fetch_valid;
      if (fetch_valid) pc_q <= fetch_pc;
    end
  end

  // lookup result: RAM output register feeds a single compare and mux
  assign hit        = q_valid && (q_tag == pc_q[PC_W-1:TAG_L]);
  assign lean_taken = q_ctr[1];
  assign pred_taken = pred_valid && hit && lean_taken;
  assign pred_pc    = pred_taken ? q_tgt : pc_q + PC_W'(4);

  always_ff @(posedge clk) begin
    if (rst) begin
      mispredict <= 1'b0;
      fix_pc     <= '0;
    end else begin
      mispredict <= res_valid &&
                    ((res_taken != res_pred_taken) ||
                     (res_taken && (res_target != res_pred_target)));
      if (res_valid) fix_pc <= res_taken ? res_target : res_pc + PC_W'(4);
    end
  end
endmodule

// File: rtl/bp_core_chk.sv
module bp_core_chk #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            fetch_valid,
  input logic [PC_W-1:0] fetch_pc,
  input logic            pred_valid,
  input logic            pred_taken,
  input logic [PC_W-1:0] pred_pc,
  input logic            res_valid,
  input logic [PC_W-1:0] res_pc,
  input logic            res_taken,
  input logic            res_pred_taken,
  input logic            mispredict,
  input logic [PC_W-1:0] fix_pc
);
  p_pred_follows_fetch_r3: assert property (@(posedge clk) disable iff (rst)
    pred_valid == $past(fetch_valid && !rst));

  p_seq_pc_r3: assert property (@(posedge clk) disable iff (rst)
    (fetch_valid && !pred_taken) |=> (pred_taken || pred_pc == $past(fetch_pc) + PC_W'(4)));

  p_dir_flush_r7: assert property (@(posedge clk) disable iff (rst)
    (res_valid && (res_taken != res_pred_taken)) |=> mispredict);

  p_quiet_flush_r7: assert property (@(posedge clk) disable iff (rst)
    !res_valid |=> !mispredict);

  p_fix_seq_r7: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_taken) |=> (fix_pc == $past(res_pc) + PC_W'(4)));

  p_idle_no_pred_r3: assert property (@(posedge clk) disable iff (rst)
    !fetch_valid |=> !pred_taken);
endmodule

bind bp_core bp_core_chk #(.PC_W(PC_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .fetch_valid    (fetch_valid),
  .fetch_pc       (fetch_pc),
  .pred_valid     (pred_valid),
  .pred_taken     (pred_taken),
  .pred_pc        (pred_pc),
  .res_valid      (res_valid),
  .res_pc         (res_pc),
  .res_taken      (res_taken),
  .res_pred_taken (res_pred_taken),
  .mispredict     (mispredict),
  .fix_pc         (fix_pc)
);

// File: tb/tb_bp_core.sv
module tb_bp_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fetch_valid = 1'b0;
  logic [31:0] fetch_pc = '0;
  logic        pred_valid, pred_taken, mispredict;
  logic [31:0] pred_pc, fix_pc;
  logic        res_valid = 1'b0, res_taken = 1'b0, res_pred_taken = 1'b0;
  logic [31:0] res_pc = '0, res_target = '0, res_pred_target = '0;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  bp_core dut (
    .clk(clk), .rst(rst), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
    .pred_valid(pred_valid), .pred_taken(pred_taken), .pred_pc(pred_pc),
    .res_valid(res_valid), .res_pc(res_pc), .res_taken(res_taken),
    .res_target(res_target), .res_pred_taken(res_pred_taken),
    .res_pred_target(res_pred_target), .mispredict(mispredict), .fix_pc(fix_pc)
  );

  // {pc, taken, target, exp_pred_taken, exp_pred_pc, exp_mispredict}
  localparam int NV = 16;
  localparam logic [98:0] VEC [NV] = '{
    {32'h100, 1'b1, 32'h080, 1'b0, 32'h104, 1'b1},  // R1 R6 cold miss
    {32'h100, 1'b1, 32'h080, 1'b1, 32'h080, 1'b0},  // R3 hit
    {32'h100, 1'b0, 32'h000, 1'b1, 32'h080, 1'b1},  // R7 direction wrong
    {32'h100, 1'b1, 32'h080, 1'b1, 32'h080, 1'b0},  // R5 still taken
    {32'h100, 1'b1, 32'h200, 1'b1, 32'h080, 1'b1},  // R7 target wrong
    {32'h100, 1'b1, 32'h200, 1'b1, 32'h200, 1'b0},  // R6 new target
    {32'h200, 1'b0, 32'h000, 1'b0, 32'h204, 1'b0},  // R2 alias tag miss
    {32'h100, 1'b1, 32'h200, 1'b1, 32'h200, 1'b0},  // R6 NT left entry
    {32'h340, 1'b1, 32'h300, 1'b0, 32'h344, 1'b1},  // R9 loop, first pass
    {32'h340, 1'b1, 32'h300, 1'b1, 32'h300, 1'b0},
    {32'h340, 1'b1, 32'h300, 1'b1, 32'h300, 1'b0},
    {32'h340, 1'b0, 32'h000, 1'b1, 32'h300, 1'b1},  // first exit
    {32'h340, 1'b1, 32'h300, 1'b1, 32'h300, 1'b0},  // re-entry predicted
    {32'h340, 1'b1, 32'h300, 1'b1, 32'h300, 1'b0},
    {32'h340, 1'b1, 32'h300, 1'b1, 32'h300, 1'b0},
    {32'h340, 1'b0, 32'h000, 1'b1, 32'h300, 1'b1}   // second exit
  };

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic fetch(input logic [31:0] pc);
    @(negedge clk);
    fetch_valid = 1'b1; fetch_pc = pc;
    @(negedge clk);
    fetch_valid = 1'b0;
  endtask

  task automatic resolve(input logic [31:0] pc, input logic tk, input logic [31:0] tgt,
                         input logic ptk, input logic [31:0] ppc);
    @(negedge clk);
    res_valid = 1'b1; res_pc = pc; res_taken = tk; res_target = tgt;
    res_pred_taken = ptk; res_pred_target = ppc;
    @(negedge clk);
    res_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int exit_misp;
    logic ptk;
    logic [31:0] ppc;
    exit_misp = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(pred_valid == 1'b0, "R1 pred_valid", 32'(pred_valid), 0);
    chk(mispredict == 1'b0, "R1 mispredict", 32'(mispredict), 0);

    for (int i = 0; i < NV; i++) begin
      logic [31:0] vpc, vtg, eppc;
      logic vtk, ept, emis;
      {vpc, vtk, vtg, ept, eppc, emis} = VEC[i];
      fetch(vpc);
      chk(pred_valid == 1'b1, "R3 pred_valid", 32'(pred_valid), 1);
      chk(pred_taken == ept, "R3 R4 pred_taken", 32'(pred_taken), 32'(ept));
      chk(pred_pc == eppc, "R3 pred_pc", pred_pc, eppc);
      ptk = pred_taken; ppc = pred_pc;
      resolve(vpc, vtk, vtg, ptk, ppc);
      chk(mispredict == emis, "R7 mispredict", 32'(mispredict), 32'(emis));
      chk(fix_pc == (vtk ? vtg : vpc + 32'd4), "R7 fix_pc", fix_pc,
          vtk ? vtg : vpc + 32'd4);
      if (i >= 12 && mispredict) exit_misp++;
      @(negedge clk);
      chk(pred_valid == 1'b0 && mispredict == 1'b0, "R3 R7 idle", 32'(mispredict), 0);
    end
    chk(exit_misp == 1, "R9 one miss per exit", 32'(exit_misp), 1);

    // R8: fetch and resolve same index, same edge
    @(negedge clk);
    fetch_valid = 1'b1; fetch_pc = 32'h480;
    res_valid = 1'b1; res_pc = 32'h480; res_taken = 1'b1; res_target = 32'h500;
    res_pred_taken = 1'b0; res_pred_target = 32'h484;
    @(negedge clk);
    fetch_valid = 1'b0; res_valid = 1'b0;
    chk(pred_taken == 1'b0, "R8 old state taken", 32'(pred_taken), 0);
    chk(pred_pc == 32'h484, "R8 old state pc", pred_pc, 32'h484);
    chk(mispredict == 1'b1, "R8 mispredict", 32'(mispredict), 1);
    fetch(32'h480);
    chk(pred_pc == 32'h500, "R8 updated pc", pred_pc, 32'h500);

    // R4: saturation at 2'b00
    resolve(32'h604, 1'b0, 32'h0, 1'b0, 32'h608);
    resolve(32'h604, 1'b0, 32'h0, 1'b0, 32'h608);
    resolve(32'h604, 1'b1, 32'h700, 1'b0, 32'h608);
    chk(mispredict == 1'b1, "R4 taken after NT", 32'(mispredict), 1);
    fetch(32'h604);
    chk(pred_taken == 1'b0, "R4 low saturation", 32'(pred_taken), 0);
    chk(pred_pc == 32'h608, "R4 low saturation pc", pred_pc, 32'h608);

    // R1: reset mid-run clears buffer validity and counters
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk(pred_valid == 1'b0 && mispredict == 1'b0, "R1 outputs after reset",
        32'(pred_valid), 0);
    fetch(32'h100);
    chk(pred_taken == 1'b0, "R1 BTB invalid after reset", 32'(pred_taken), 0);
    chk(pred_pc == 32'h104, "R1 sequential after reset", pred_pc, 32'h104);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule